// File: doc/BRIEF.md
# Guarded Watchdog Timer

The block is a watchdog timer that counts pulses from a free-running slow tick already synchronised into the system clock domain. Software restarts the count with a kick strobe. If the count reaches the selected timeout while the watchdog is enabled, the block issues a one-cycle reset request and raises a sticky flag that records the watchdog as the cause of the reset.

The enable bit and the four-bit timeout code can change only through a two-step sequence. The first write sets both the change-enable bit and the enable bit, which opens a short window. The next write inside that window loads the new settings. A program that has run away is unlikely to hit that sequence by chance.

The enable cannot be dropped while the watchdog-reset flag is set. A strap input can hold the watchdog on permanently. A warm reset (any reset except power-on) keeps the enable bit and selects the shortest timeout.

Top module: `guard_watchdog`

## Requirements
- R1: After power-on reset the control readback is 0, the flag is 0 and no reset request is issued.
- R2: Control layout: bits 2..0 are timeout code bits 2..0, bit 3 is enable, bit 4 is change-enable, and bit 5 is code bit 3. Readback uses the same layout, and bit 3 reads 1 when the strap forces the watchdog on.
- R3: A control write with bits 4 and 3 both set, made while the window is closed, opens the window. Readback bit 4 is 1 while the window is open.
- R4: After the opening write, a write on any of the next WIN_CYCLES (4) clocks loads the enable and code bits and closes the window. If no write comes, the window closes after those clocks. A write made while the window is closed changes neither the enable nor the code.
- R5: While enabled, timeout code N expires after 2^(BASE_LOG2+N) counted ticks (BASE_LOG2 = 11 by default). Codes 10 to 15 behave as code 9.
- R6: A kick clears the count. No ticks are counted while the watchdog is disabled, and a configuration load restarts the count.
- R7: On expiry the reset request is high for exactly one clock, starting one clock after the edge that counts the final tick, and counting starts again from zero.
- R8: The flag is set on expiry and cleared by the flag-clear strobe. While the flag is set, a write of enable = 0 leaves the watchdog enabled.
- R9: A warm reset sets the code to 0, closes the window and clears the count. It keeps both the enable bit and the flag.
- R10: With the force-on strap high, the watchdog is enabled, reads enable = 1 and keeps expiring, and writes that disable it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| tick | input | 1 | Single-cycle slow time-base pulse |
| kick | input | 1 | Restart strobe |
| force_on | input | 1 | Strap that holds the watchdog enabled |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data |
| flag_clr | input | 1 | Clears the watchdog-reset flag |
| ctrl_rdata | output | 6 | Control readback |
| wdr_flag | output | 1 | Watchdog-reset flag |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted window counter shows up in the readback of bit 4 on the next clock. It also shows up as a write that is accepted or rejected one slot off, which the bench probes on each side of the boundary. A wrong code decode or tap selection moves the reset request by a power of two in the number of ticks, so measuring the exact tick count for every code and for one saturated code exposes it at the first expiry. A fault in the enable hold, the warm-reset handling or the strap path appears as a wrong bit 3 in the readback within one clock of the write or reset that triggers it.

// File: rtl/guard_watchdog_pkg.sv
package guard_watchdog_pkg;
   localparam int CTRL_W      = 6;
   localparam int CODE_W      = 4;
   localparam int CODE_LO_BIT = 0;
   localparam int EN_BIT      = 3;
   localparam int CE_BIT      = 4;
   localparam int CODE_HI_BIT = 5;

   typedef struct packed {
      logic              en;
      logic [CODE_W-1:0] code;
   } wd_cfg_t;
endpackage

// File: rtl/guard_watchdog_unlock.sv
module guard_watchdog_unlock
   import guard_watchdog_pkg::*;
#(
   parameter int WIN_CYCLES = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              hold_en,
   output wd_cfg_t           cfg,
   output logic              win_open,
   output logic              cfg_load
);
   localparam int WIN_W = $clog2(WIN_CYCLES + 1);

   logic [WIN_W-1:0] win_q;
   wd_cfg_t          cfg_q;
   logic             unlock_req;

   assign win_open   = (win_q != '0);
   assign cfg_load   = rst_n && win_open && we;
   assign unlock_req = we && wdata[CE_BIT] && wdata[EN_BIT];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         win_q <= '0;
         cfg_q <= '0;
      end else if (!rst_n) begin
         win_q       <= '0;
         cfg_q.code  <= '0;
      end else if (win_open) begin
         if (we) begin
            cfg_q.en   <= wdata[EN_BIT] | hold_en;
            cfg_q.code <= {wdata[CODE_HI_BIT], wdata[CODE_LO_BIT +: 3]};
            win_q      <= '0;
         end else begin
            win_q <= win_q - WIN_W'(1);
         end
      end else if (unlock_req) begin
         win_q <= WIN_W'(WIN_CYCLES);
      end
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/guard_watchdog_tap.sv
module guard_watchdog_tap
   import guard_watchdog_pkg::*;
#(
   parameter int BASE_LOG2 = 11,
   parameter int MAX_CODE  = 9,
   localparam int CNT_W    = BASE_LOG2 + MAX_CODE
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CODE_W-1:0] code,
   output logic              terminal
);
   logic [MAX_CODE:0] hit;
   logic [CODE_W-1:0] sat_code;

   assign sat_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;

   for (genvar g = 0; g <= MAX_CODE; g++) begin : g_tap
      assign hit[g] = &cnt[BASE_LOG2+g-1:0];
   end

   assign terminal = hit[sat_code];
endmodule

// File: rtl/guard_watchdog_count.sv
module guard_watchdog_count #(
   parameter int BASE_LOG2 = 11,
   parameter int MAX_CODE  = 9,
   localparam int CNT_W    = BASE_LOG2 + MAX_CODE
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             kick,
   input  logic             cfg_load,
   input  logic             terminal,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             req,
   output logic             flag
);
   logic [CNT_W-1:0] cnt_q;
   logic             req_q, flag_q;
   logic             restart, expire;

   assign restart = !rst_n || cfg_load || kick || !run;
   assign expire  = !restart && tick && terminal;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q  <= '0;
         req_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         req_q <= expire;
         if (expire)        flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         if (restart || expire) cnt_q <= '0;
         else if (tick)         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt  = cnt_q;
   assign req  = req_q;
   assign flag = flag_q;
endmodule

// File: rtl/guard_watchdog.sv
module guard_watchdog
   import guard_watchdog_pkg::*;
#(
   parameter int BASE_LOG2  = 11,
   parameter int MAX_CODE   = 9,
   parameter int WIN_CYCLES = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              kick,
   input  logic              force_on,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              flag_clr,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic              wdr_flag,
   output logic              reset_req
);
   localparam int CNT_W = BASE_LOG2 + MAX_CODE;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("BASE_LOG2 must be at least 1");
   end
   if (MAX_CODE < 0 || MAX_CODE > (1 << CODE_W) - 1) begin : g_bad_code
      $error("MAX_CODE out of range for the code field");
   end
   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("WIN_CYCLES must be at least 1");
   end

   wd_cfg_t          cfg;
   logic             win_open, cfg_load, terminal, run;
   logic [CNT_W-1:0] cnt;

   guard_watchdog_unlock #(.WIN_CYCLES(WIN_CYCLES)) unlock_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(ctrl_we),
      .wdata(ctrl_wdata), .hold_en(wdr_flag), .cfg(cfg),
      .win_open(win_open), .cfg_load(cfg_load)
   );

   assign run = cfg.en | force_on;

   guard_watchdog_tap #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) tap_i (
      .cnt(cnt), .code(cfg.code), .terminal(terminal)
   );

   guard_watchdog_count #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) count_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .run(run), .tick(tick),
      .kick(kick), .cfg_load(cfg_load), .terminal(terminal),
      .flag_clr(flag_clr), .cnt(cnt), .req(reset_req), .flag(wdr_flag)
   );

   always_comb begin
      ctrl_rdata                  = '0;
      ctrl_rdata[CODE_LO_BIT +: 3] = cfg.code[2:0];
      ctrl_rdata[EN_BIT]          = run;
      ctrl_rdata[CE_BIT]          = win_open;
      ctrl_rdata[CODE_HI_BIT]     = cfg.code[3];
   end
endmodule

// File: rtl/guard_watchdog_chk.sv
module guard_watchdog_chk
   import guard_watchdog_pkg::*;
(
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic              force_on,
   input logic [CTRL_W-1:0] ctrl_rdata,
   input logic              wdr_flag,
   input logic              reset_req
);
   p_req_pulse_r7: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |=> !reset_req);

   p_req_sets_flag_r8: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |-> wdr_flag);

   p_req_needs_en_r5: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |-> $past(ctrl_rdata[EN_BIT]));

   p_flag_holds_en_r8: assert property (@(posedge clk) disable iff (!por_n)
      (wdr_flag && ctrl_rdata[EN_BIT] && !force_on) |=> ctrl_rdata[EN_BIT]);

   p_closed_no_change_r4: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && !ctrl_rdata[CE_BIT]) |=>
         $stable({ctrl_rdata[CODE_HI_BIT], ctrl_rdata[2:0]}));

   p_warm_code_r9: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> (ctrl_rdata[2:0] == 3'd0 && !ctrl_rdata[CODE_HI_BIT]
                  && !ctrl_rdata[CE_BIT]));
endmodule

bind guard_watchdog guard_watchdog_chk chk_i (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .force_on(force_on),
   .ctrl_rdata(ctrl_rdata), .wdr_flag(wdr_flag), .reset_req(reset_req)
);

// File: tb/guard_watchdog_tb.sv
module guard_watchdog_tb_top;
   localparam int BASE = 2;
   localparam int MAXC = 9;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b1, tick = 1'b0, kick = 1'b0;
   logic force_on = 1'b0, ctrl_we = 1'b0, flag_clr = 1'b0;
   logic [5:0] ctrl_wdata = '0;
   logic [5:0] ctrl_rdata;
   logic wdr_flag, reset_req;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   guard_watchdog #(.BASE_LOG2(BASE), .MAX_CODE(MAXC), .WIN_CYCLES(4)) dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .kick(kick),
      .force_on(force_on), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .flag_clr(flag_clr), .ctrl_rdata(ctrl_rdata), .wdr_flag(wdr_flag),
      .reset_req(reset_req)
   );

   function automatic int exp_ticks(int code);
      int c = (code > MAXC) ? MAXC : code;
      return 1 << (BASE + c);
   endfunction

   function automatic logic [5:0] ctrl_word(bit en, int code);
      logic [3:0] c = 4'(code);
      return {c[3], 1'b0, en, c[2:0]};
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] d);
      ctrl_we = 1'b1; ctrl_wdata = d;
      @(negedge clk);
      ctrl_we = 1'b0; ctrl_wdata = '0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(bit en, int code);
      wr(6'h18);
      wr(ctrl_word(en, code));
   endtask

   task automatic clr_flag();
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic run_to_req(output int k);
      k = 0;
      tick = 1'b1;
      while (k < 5000) begin
         @(negedge clk);
         k++;
         if (reset_req) break;
      end
      tick = 1'b0;
   endtask

   task automatic warm();
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      int k;
      logic [5:0] m_ctrl;
      bit m_en, m_flag;
      int m_win;
      logic [3:0] m_code;
      void'($urandom(32'd1234));
      idle(2);
      por_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 ctrl", ctrl_rdata, 0);
      chk("R1 flag", wdr_flag, 0);
      chk("R1 req", reset_req, 0);
      // R4 closed write ignored
      wr(6'h0D);
      chk("R4 closed write", ctrl_rdata, 0);
      // R3 unlock opens window
      wr(6'h18);
      chk("R3 ce set", ctrl_rdata[4], 1);
      wr(ctrl_word(1'b1, 3));
      // R2 layout
      chk("R2 readback", ctrl_rdata, 6'h0B);
      // R4 window boundary: slot 4 accepted
      wr(6'h18); idle(3); wr(ctrl_word(1'b1, 9));
      chk("R4 last slot", ctrl_rdata, 6'h29);
      wr(6'h18); idle(4);
      chk("R4 window closed", ctrl_rdata[4], 0);
      wr(ctrl_word(1'b1, 2));
      chk("R4 late write", ctrl_rdata, 6'h29);
      // R6 no ticks while disabled
      cfg(1'b0, 0);
      tick = 1'b1;
      k = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (reset_req) k++; end
      tick = 1'b0;
      chk("R6 disabled no req", k, 0);
      // R5 each code plus a saturated code
      for (int c = 0; c <= 10; c++) begin
         int code = (c == 10) ? 12 : c;
         cfg(1'b1, code);
         run_to_req(k);
         chk($sformatf("R5 code %0d ticks", code), k, exp_ticks(code));
         @(negedge clk);
         chk("R7 one-cycle pulse", reset_req, 0);
         chk("R8 flag set", wdr_flag, 1);
         clr_flag();
         chk("R8 flag cleared", wdr_flag, 0);
      end
      // R6 kick keeps it quiet, then expiry 4 ticks after last kick
      cfg(1'b1, 0);
      tick = 1'b1; k = 0;
      for (int i = 0; i < 40; i++) begin
         kick = (i % 2 == 0); @(negedge clk); if (reset_req) k++;
      end
      kick = 1'b1; @(negedge clk); kick = 1'b0;
      chk("R6 kicked no req", k, 0);
      tick = 1'b0;
      run_to_req(k);
      chk("R6 ticks after kick", k, 4);
      // R8 cannot disable while flag set
      cfg(1'b0, 0);
      chk("R8 en held by flag", ctrl_rdata[3], 1);
      clr_flag();
      cfg(1'b0, 0);
      chk("R8 disable after clear", ctrl_rdata, 0);
      // R9 warm reset
      cfg(1'b1, 5);
      warm();
      chk("R9 warm ctrl", ctrl_rdata, 6'h08);
      chk("R9 warm flag", wdr_flag, 0);
      run_to_req(k);
      chk("R9 shortest after warm", k, 4);
      warm();
      chk("R9 flag kept", wdr_flag, 1);
      clr_flag(); cfg(1'b0, 0);
      // R10 force on
      force_on = 1'b1; @(negedge clk);
      chk("R10 en read", ctrl_rdata, 6'h08);
      run_to_req(k);
      chk("R10 expiry", k, 4);
      clr_flag(); cfg(1'b0, 0);
      chk("R10 disable ignored", ctrl_rdata[3], 1);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      force_on = 1'b0; @(negedge clk);
      chk("R10 strap released", ctrl_rdata, 0);
      // Random configuration traffic against a bench model (R3 R4 R8)
      m_en = 0; m_flag = 0; m_win = 0; m_code = 0;
      for (int i = 0; i < 300; i++) begin
         logic [5:0] d = 6'($urandom);
         bit w = ($urandom % 3) != 0;
         if (($urandom % 4) == 0) d = 6'h18 | d[5:0] & 6'h27 | 6'h18;
         ctrl_we = w; ctrl_wdata = d;
         @(negedge clk);
         if (m_win > 0) begin
            if (w) begin
               m_en = d[3] | m_flag; m_code = {d[5], d[2:0]}; m_win = 0;
            end else m_win--;
         end else if (w && d[4] && d[3]) m_win = 4;
         m_ctrl = {m_code[3], m_win != 0, m_en, m_code[2:0]};
         chk("R4 random model", ctrl_rdata, m_ctrl);
      end
      ctrl_we = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule